// File: doc/BRIEF.md
# Byte-Wide SPI Transfer Controller

This block moves one byte at a time over a four-wire serial link and can take either side of that link. A control bit picks the role. As master it makes the serial clock itself, only while a byte is in flight, at one quarter of the system clock. As slave it follows a clock and select that arrive from outside, passing them through two-stage synchronisers first. The outgoing and incoming lines shift together, so every byte that leaves is paired with one that arrives. Bytes go out most significant bit first, in clock mode 0: inputs are sampled on the rising edge and outputs change on the falling edge.

The host sees a small register port: a control register, a read-only status register and a data register. A data write loads the shift register directly, because transmit has only one buffer. That write is refused while a byte is shifting, and the refusal sets a collision flag. On the receive side, each finished byte is copied into a holding buffer. The host can therefore read it at any time until the next byte finishes. A completion flag drives an interrupt line, gated by a local enable and a global enable.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: In master mode, a data write (address 2) while idle sends the byte MSB first on `mosi_o`. It captures `miso_i` into the receive byte with exactly 8 rising SCK edges, each SCK period lasting 4 clocks and SCK resting low. The completion flag becomes visible 32 clocks after the write edge and not one clock earlier.
- R2: The enable bits follow the role.
  - Master (control bit 6 = enable, bit 4 = master): `sck_oe`, `mosi_oe` and `ss_oe` are high and `miso_oe` is low. `ss_n_o` is low while a byte shifts. `sck_o` is high only during a transfer.
  - Slave: only `miso_oe` may be high, and only while `ss_n_i` is low.
  - Disabled: no output enable is high.
- R3: A data write during a transfer does not touch the byte in flight. It sets the collision flag (status bit 6).
- R4: At completion the received byte goes into the receive buffer. A data read returns that buffer, so a read taken in the middle of a transfer returns the previous byte.
- R5: If the buffer is not read before the next transfer finishes, the newer byte overwrites it.
- R6: Completion sets the done flag (status bit 7).
- R7: `irq` is high exactly when the done flag, control bit 7 and `glb_ie` are all set.
- R8: A status read (address 1) that sees the done flag set, followed by a data access, clears both flags. A data access with no such status read before it leaves the done flag set. `irq_ack` clears the done flag.
- R9: In slave mode with `ss_n_i` low, an externally driven mode-0 byte on `mosi_i` is received, and the previously written byte is returned on `miso_o`, MSB first.
- R10: In slave mode, `ss_n_i` rising during a byte discards the partial byte without setting any flag. The next full byte is received correctly.
- R11: After reset, control, status and data read back as 0, `irq` and `sck_o` are low, and no output enable is high.
- R12: A data write while the block is disabled produces no SCK edge and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| glb_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears done flag |
| irq | output | 1 | Gated completion interrupt |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_i | input | 1 | Master-out line in (slave) |
| mosi_o | output | 1 | Master-out line out (master) |
| mosi_oe | output | 1 | Master-out drive enable |
| miso_i | input | 1 | Slave-out line in (master) |
| miso_o | output | 1 | Slave-out line out (slave) |
| miso_oe | output | 1 | Slave-out drive enable |
| ss_n_i | input | 1 | Active-low select in (slave) |
| ss_n_o | output | 1 | Active-low select out (master) |
| ss_oe | output | 1 | Select drive enable |

## Verification
The hardest state to reach from the ports is a slave whose select is withdrawn in the middle of a byte. Reaching it takes a bench-driven clock that is slow compared with the synchronisers, and a stop after a few bits. The stimulus drives three mode-0 bits, raises `ss_n_i` and checks that no flag rises. It then writes a fresh reply byte and runs a complete byte, which must land intact in both directions. The collision case and the one-cycle-early flag probe are timed against the known 32-clock transfer length.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int BUS_W = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  // control register bit positions
  localparam int C_IE  = 7;
  localparam int C_EN  = 6;
  localparam int C_MST = 4;
  typedef enum logic [1:0] {ROLE_OFF, ROLE_SLAVE, ROLE_MASTER} role_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int N = 3,
  parameter int STG = 2,
  parameter logic [N-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg_q [STG];

  for (genvar g = 0; g < STG; g++) begin : g_stage
    logic [N-1:0] stg_n;
    if (g == 0) begin : g_first
      assign stg_n = d;
    end else begin : g_rest
      assign stg_n = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_V;
      else        stg_q[g] <= stg_n;
    end
  end

  assign q = stg_q[STG-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic stop,
  output logic sck,
  output logic smp_stb,
  output logic sft_stb,
  output logic active
);
  localparam int HALF = DIV / 2;
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] D_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] D_MID  = CW'(HALF - 1);
  localparam logic [CW-1:0] D_HI   = CW'(HALF);

  logic [CW-1:0] div_q, div_n;
  logic          act_n;

  assign smp_stb = active && (div_q == D_MID);
  assign sft_stb = active && (div_q == D_LAST);
  assign sck     = active && (div_q >= D_HI);

  always_comb begin
    act_n = active;
    div_n = div_q;
    if (!en) begin
      act_n = 1'b0;
      div_n = '0;
    end else if (start && !active) begin
      act_n = 1'b1;
      div_n = '0;
    end else if (active) begin
      div_n = (div_q == D_LAST) ? '0 : div_q + 1'b1;
      if (sft_stb && stop) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      div_q  <= '0;
    end else begin
      active <= act_n;
      div_q  <= div_n;
    end
  end

  // clock generation only stops on the final shift or on disable
  assert_stop_on_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) && $past(en)) |-> $past(sft_stb && stop));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          smp_stb,
  input  logic          sft_stb,
  input  logic          abort,
  input  logic          din,
  output logic          so,
  output logic [DW-1:0] rx_byte,
  output logic          done,
  output logic          mid
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] C_LAST = CW'(DW - 1);

  logic [DW-1:0] sh_q, sh_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          smp_q, smp_n;

  assign so      = sh_q[DW-1];
  assign rx_byte = {sh_q[DW-2:0], smp_q};
  assign done    = sft_stb && !abort && !load && (cnt_q == C_LAST);
  assign mid     = (cnt_q != '0);

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    smp_n = smp_q;
    if (load) begin
      sh_n  = ld_data;
      cnt_n = '0;
    end else if (abort) begin
      cnt_n = '0;
    end else begin
      if (smp_stb) smp_n = din;
      if (sft_stb) begin
        sh_n  = {sh_q[DW-2:0], smp_q};
        cnt_n = (cnt_q == C_LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      smp_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      smp_q <= smp_n;
    end
  end

  // after the final shift the bit counter is back at the byte boundary
  assert_byte_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mid);
  // an abort always returns the counter to the boundary
  assert_abort_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !load) |=> !mid);
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              busy,
  input  logic              xfer_done,
  input  logic [DW-1:0]     rx_byte,
  input  logic              irq_ack,
  input  logic              glb_ie,
  output logic              en,
  output logic              mst,
  output logic              load,
  output logic              irq
);
  logic [DW-1:0] ctrl_q, ctrl_n, rxb_q, rxb_n;
  logic          done_q, done_n, col_q, col_n, arm_q, arm_n;
  logic          dat_acc, dat_wr, col_hit;

  assign en      = ctrl_q[C_EN];
  assign mst     = ctrl_q[C_MST];
  assign dat_acc = (wr_en || rd_en) && (addr == A_DATA);
  assign dat_wr  = wr_en && (addr == A_DATA) && ctrl_q[C_EN];
  assign load    = dat_wr && !busy;
  assign col_hit = dat_wr && busy;
  assign irq     = done_q && ctrl_q[C_IE] && glb_ie;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_STAT:  rdata = {done_q, col_q, {(DW-2){1'b0}}};
      A_DATA:  rdata = rxb_q;
      default: rdata = '0;
    endcase
  end

  always_comb begin
    ctrl_n = ctrl_q;
    rxb_n  = rxb_q;
    done_n = done_q;
    col_n  = col_q;
    arm_n  = arm_q;
    if (wr_en && addr == A_CTRL) ctrl_n = wdata;
    if (dat_acc && arm_q) begin
      done_n = 1'b0;
      col_n  = 1'b0;
      arm_n  = 1'b0;
    end
    if (rd_en && addr == A_STAT && done_q) arm_n = 1'b1;
    if (irq_ack) begin
      done_n = 1'b0;
      arm_n  = 1'b0;
    end
    if (col_hit) col_n = 1'b1;
    if (xfer_done) begin
      done_n = 1'b1;
      rxb_n  = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rxb_q  <= '0;
      done_q <= 1'b0;
      col_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      rxb_q  <= rxb_n;
      done_q <= done_n;
      col_q  <= col_n;
      arm_q  <= arm_n;
    end
  end

  assert_rx_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (rxb_q == $past(rx_byte)));
  assert_col_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA && en && busy) |=> col_q);
  assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> done_q);
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_pkg::*;
#(
  parameter int DW = 8,
  parameter int CLK_DIV = 4,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              glb_ie,
  input  logic              irq_ack,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i,
  output logic              ss_n_o,
  output logic              ss_oe
);
  localparam int PIN_N = 3;
  localparam int P_SCK = 0;
  localparam int P_MOSI = 1;
  localparam int P_SS = 2;

  logic [1:0]       rst_q;
  logic             rst_int_n;
  logic             en, mst, load, busy, xfer_done, mid;
  logic             c_sck, c_smp, c_sft, c_act;
  logic             smp, sft, abort, din, so;
  logic [DW-1:0]    rx_byte;
  logic [PIN_N-1:0] pins_q;
  logic             sck_prev_q;
  logic             s_rise, s_fall, s_sel;
  role_e            role;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  always_comb begin
    if (!en)      role = ROLE_OFF;
    else if (mst) role = ROLE_MASTER;
    else          role = ROLE_SLAVE;
  end

  spi_edge_sync #(.N(PIN_N), .STG(SYNC_STG), .RST_V(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({ss_n_i, mosi_i, sck_i}), .q(pins_q)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sck_prev_q <= 1'b0;
    else            sck_prev_q <= pins_q[P_SCK];
  end

  assign s_sel  = (role == ROLE_SLAVE) && !pins_q[P_SS];
  assign s_rise = s_sel && pins_q[P_SCK] && !sck_prev_q;
  assign s_fall = s_sel && !pins_q[P_SCK] && sck_prev_q;

  spi_clkgen #(.DIV(CLK_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_int_n), .en(role == ROLE_MASTER),
    .start(load && role == ROLE_MASTER), .stop(xfer_done),
    .sck(c_sck), .smp_stb(c_smp), .sft_stb(c_sft), .active(c_act)
  );

  always_comb begin
    case (role)
      ROLE_MASTER: begin
        smp = c_smp; sft = c_sft; din = miso_i; abort = 1'b0; busy = c_act;
      end
      ROLE_SLAVE: begin
        smp = s_rise; sft = s_fall; din = pins_q[P_MOSI];
        abort = pins_q[P_SS]; busy = mid;
      end
      default: begin
        smp = 1'b0; sft = 1'b0; din = 1'b0; abort = 1'b1; busy = 1'b0;
      end
    endcase
  end

  spi_shift_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_int_n), .load(load), .ld_data(bus_wdata),
    .smp_stb(smp), .sft_stb(sft), .abort(abort), .din(din),
    .so(so), .rx_byte(rx_byte), .done(xfer_done), .mid(mid)
  );

  spi_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .busy(busy), .xfer_done(xfer_done), .rx_byte(rx_byte),
    .irq_ack(irq_ack), .glb_ie(glb_ie), .en(en), .mst(mst),
    .load(load), .irq(irq)
  );

  assign sck_o   = (role == ROLE_MASTER) && c_sck;
  assign sck_oe  = (role == ROLE_MASTER);
  assign mosi_oe = (role == ROLE_MASTER);
  assign ss_oe   = (role == ROLE_MASTER);
  assign miso_oe = s_sel;
  assign ss_n_o  = !((role == ROLE_MASTER) && c_act);
  assign mosi_o  = so;
  assign miso_o  = so;

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (role == ROLE_MASTER && !busy) |-> !sck_o);
  assert_sck_selects_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    sck_o |-> (!ss_n_o && sck_oe));
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> glb_ie);
  assert_no_done_deselected_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (role == ROLE_SLAVE && pins_q[P_SS]) |-> !xfer_done);
endmodule

// File: tb/test_spi_xfer_ctrl.sv
`timescale 1ns/1ps
module test_spi_xfer_ctrl;
  localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2;
  localparam int NV = 6;
  // {tx byte, reply from modelled slave}
  localparam logic [15:0] VEC [NV] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00,
                                       16'h81_7E, 16'h5A_C3, 16'h01_80};

  logic clk = 1'b0;
  logic rst_n, bus_wr, bus_rd, glb_ie, irq_ack, irq;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic sck_i, sck_o, sck_oe, mosi_i, mosi_o, mosi_oe;
  logic miso_i, miso_o, miso_oe, ss_n_i, ss_n_o, ss_oe;

  int n_chk = 0, n_bad = 0;
  int tb_rises = 0;
  logic [2:0] tb_fidx = 3'd0;
  logic [7:0] tb_got = 8'h00;
  logic [7:0] tb_resp;

  always #10 clk = ~clk;

  spi_xfer_ctrl i_spi_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .glb_ie(glb_ie), .irq_ack(irq_ack), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i), .ss_n_o(ss_n_o), .ss_oe(ss_oe)
  );

  // modelled external slave for master mode
  assign miso_i = tb_resp[~tb_fidx];
  always @(posedge sck_o) begin
    tb_rises = tb_rises + 1;
    tb_got = {tb_got[6:0], mosi_o};
  end
  always @(negedge sck_o) tb_fidx = tb_fidx + 3'd1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic sl_bits(input logic [7:0] din, input int nb, output logic [7:0] got);
    got = 8'h00;
    for (int b = 0; b < nb; b++) begin
      mosi_i = din[7-b];
      repeat (6) @(negedge clk);
      got[7-b] = miso_o;
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, got;
    int r0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = AC; bus_wdata = 8'h00;
    glb_ie = 1'b1; irq_ack = 1'b0; sck_i = 1'b0; mosi_i = 1'b0; ss_n_i = 1'b1;
    tb_resp = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    peek(AC, v); chk("R11 ctrl", v, 8'h00);
    peek(AS, v); chk("R11 status", v, 8'h00);
    peek(AD, v); chk("R11 data", v, 8'h00);
    chk("R11 outputs", {irq, sck_o, sck_oe, mosi_oe, miso_oe, ss_oe}, 6'b0);

    // R12 disabled write ignored
    r0 = tb_rises;
    wr(AD, 8'h77);
    repeat (40) @(negedge clk);
    chk("R12 no sck", tb_rises - r0, 0);
    peek(AS, v); chk("R12 no flag", v, 8'h00);

    // master, irq enabled: ctrl bit7 ie, bit6 en, bit4 master
    wr(AC, 8'hD0);
    chk("R2 master oe", {sck_oe, mosi_oe, ss_oe, miso_oe}, 4'b1110);

    // table of master exchanges: R1 R4 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      tb_resp = VEC[i][7:0];
      r0 = tb_rises;
      wr(AD, VEC[i][15:8]);
      repeat (32) @(negedge clk);
      chk("R1 mosi byte", tb_got, VEC[i][15:8]);
      chk("R1 sck edges", tb_rises - r0, 8);
      peek(AS, v); chk("R6 done flag", v, 8'h80);
      chk("R7 irq on", irq, 1'b1);
      rd(AS, v);
      rd(AD, v); chk("R4 rx byte", v, VEC[i][7:0]);
      peek(AS, v); chk("R8 cleared", v, 8'h00);
    end

    // R1 exact completion cycle, R4 mid-transfer read, R2 select
    tb_resp = 8'h69;
    wr(AD, 8'h96);
    repeat (10) @(negedge clk);
    peek(AD, v); chk("R4 old byte mid-xfer", v, 8'h80);
    chk("R2 ss low in xfer", ss_n_o, 1'b0);
    repeat (21) @(negedge clk);
    peek(AS, v); chk("R1 not early", v, 8'h00);
    @(negedge clk);
    peek(AS, v); chk("R1 done at 32", v, 8'h80);
    chk("R2 ss high idle", ss_n_o, 1'b1);

    // R7 gating
    glb_ie = 1'b0; #1 chk("R7 global off", irq, 1'b0);
    glb_ie = 1'b1;
    wr(AC, 8'h50); chk("R7 local off", irq, 1'b0);
    wr(AC, 8'hD0); chk("R7 both on", irq, 1'b1);

    // R8 data read without status read keeps flag; ack clears it
    rd(AD, v); chk("R5 prior byte", v, 8'h69);
    peek(AS, v); chk("R8 flag kept", v, 8'h80);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    peek(AS, v); chk("R8 ack clears", v, 8'h00);

    // R5 overwrite
    tb_resp = 8'h11; wr(AD, 8'h22); repeat (34) @(negedge clk);
    tb_resp = 8'h33; wr(AD, 8'h44); repeat (34) @(negedge clk);
    peek(AD, v); chk("R5 overwritten", v, 8'h33);
    rd(AS, v); rd(AD, v);

    // R3 collision
    tb_resp = 8'hE7;
    wr(AD, 8'h3C);
    repeat (10) @(negedge clk);
    wr(AD, 8'h55);
    repeat (25) @(negedge clk);
    chk("R3 byte unchanged", tb_got, 8'h3C);
    rd(AS, v); chk("R3 col flag", v, 8'hC0);
    rd(AD, v); chk("R3 rx intact", v, 8'hE7);
    peek(AS, v); chk("R8 both clear", v, 8'h00);

    // slave mode
    wr(AC, 8'h40);
    chk("R2 slave idle oe", {sck_oe, mosi_oe, ss_oe, miso_oe}, 4'b0000);
    wr(AD, 8'h96);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 slave selected", miso_oe, 1'b1);
    sl_bits(8'h5B, 8, got);
    chk("R9 miso byte", got, 8'h96);
    rd(AS, v); chk("R9 flag", v, 8'h80);
    rd(AD, v); chk("R9 rx", v, 8'h5B);

    // R10 partial byte dropped
    sl_bits(8'hE0, 3, got);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    peek(AS, v); chk("R10 no flag", v, 8'h00);
    chk("R2 deselected oe", miso_oe, 1'b0);
    wr(AD, 8'hC3);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    sl_bits(8'h2D, 8, got);
    chk("R10 miso after abort", got, 8'hC3);
    rd(AS, v); rd(AD, v); chk("R10 rx after abort", v, 8'h2D);
    ss_n_i = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule